// File: doc/BRIEF.md
# Run-Time Configurable CIC Decimator with Output Gain

This block converts a one-bit pulse-density stream into signed 24-bit samples. Each accepted input bit is mapped to +1 or -1 and fed through a cascade of integrators. On every R-th accepted bit the integrator result passes through a matching cascade of combs. The comb result is then multiplied by an unsigned 8-bit gain, arithmetically shifted right and clamped to 24 bits.

The stage count, the decimation ratio, the gain multiplier, the gain shift and a filter enable all come from one 32-bit control word. Configuration is read live. When the enable bit drops, every piece of filter state is cleared, so a stream restarts from a clean history.

The default control word, 0x95800087, selects 7 stages, decimation by 8, multiplier 0x80 and shift 21.

Top module: `cic_decim`

## Requirements
- R1: Control word fields: stage count in bits 3:0, decimation ratio in bits 8:4, gain multiplier in bits 23:16, gain shift in bits 29:24, enable in bit 31. Bits 15:9 and bit 30 have no effect on the output.
- R2: An input bit is accepted only when pdmValid and enable are both high. Bit value 1 is taken as +1 and bit value 0 as -1.
- R3: pcmValid pulses high for exactly one cycle on every R-th accepted bit since enable. The pulse appears on the clock edge that accepts that bit. A ratio field of 0 acts as ratio 1.
- R4: At each output, the filter value equals the mapped input history convolved with N cascaded boxcars of length R. History from before enable counts as zero. The history includes the bit that completes the block.
- R5: The stage count N ranges from 0 to 15. Stages beyond N are bypassed and held at zero, so N=0 outputs the mapped value of the completing bit.
- R6: The output is the filter value times the unsigned multiplier, arithmetically shifted right by the shift field. The result is saturated to the range -8388608 to 8388607.
- R7: While enable is low, the decimation count and all integrator and comb state are cleared. From the next edge on, pcmValid is 0 and pcmSample is 0.
- R8: After reset, pcmValid is 0 and pcmSample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWord | input | 32 | Control word: stages, ratio, multiplier, shift, enable |
| pdmBit | input | 1 | One-bit density-modulated input |
| pdmValid | input | 1 | Input bit strobe |
| pcmSample | output | 24 | Signed decimated sample, held between strobes |
| pcmValid | output | 1 | Output sample strobe |

## Verification
The default setting is driven with a pseudo-random bit pattern. This shows that the integrator and comb orders line up with an N-fold boxcar response, including the startup transient.

Constant all-ones and all-zeros runs at unity shift drive the gain stage into both saturation rails. A maximal shift shows that the arithmetic shift keeps the sign.

Stage counts of 0 and 15, together with ratios of 0, 2 and 31 under gapped input strobes, separate the bypass logic and the decimation phase from the accumulation. A disable in mid-stream, with strobes still arriving, shows that the history is really cleared rather than just paused.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int MAX_STAGES = 15;
  localparam int MAX_RATIO  = 31;
  localparam int STAGE_W    = $clog2(MAX_STAGES + 1);
  localparam int RATIO_W    = $clog2(MAX_RATIO + 1);
  localparam int MULT_W     = 8;
  localparam int SHIFT_W    = 6;
  localparam int OUT_W      = 24;
  localparam int ACC_W      = MAX_STAGES * $clog2(MAX_RATIO) + 2;

  localparam logic [31:0] CTRL_DEFAULT = 32'h9580_0087;

  typedef struct packed {
    logic clear;
    logic integ;
    logic dump;
  } cic_strobe_t;

  typedef struct packed {
    logic               enable;
    logic [SHIFT_W-1:0] shift;
    logic [MULT_W-1:0]  mult;
    logic [RATIO_W-1:0] ratio;
    logic [STAGE_W-1:0] stages;
  } cic_cfg_t;
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int RATIO_BITS = RATIO_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic [RATIO_BITS-1:0] ratio,
  input  logic                  inValid,
  output cic_strobe_t           strobe
);
  logic [RATIO_BITS-1:0] phase;
  logic [RATIO_BITS-1:0] ratioEff;
  logic                  lastPhase;

  assign ratioEff  = (ratio == '0) ? RATIO_BITS'(1) : ratio;
  assign lastPhase = (phase >= ratioEff - RATIO_BITS'(1));

  always_comb begin
    strobe.clear = !enable;
    strobe.integ = enable && inValid;
    strobe.dump  = enable && inValid && lastPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phase <= '0;
    else if (strobe.clear)    phase <= '0;
    else if (strobe.integ)    phase <= lastPhase ? '0 : phase + RATIO_BITS'(1);
  end

  // R3: the phase resets after each output block
  p_phase_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dump |=> (phase == '0));
endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
#(
  parameter int NSTAGE = MAX_STAGES,
  parameter int SW     = STAGE_W,
  parameter int AW     = ACC_W,
  parameter int MW     = MULT_W,
  parameter int HW     = SHIFT_W,
  parameter int OW     = OUT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cic_strobe_t          strobe,
  input  logic [SW-1:0]        nStages,
  input  logic [MW-1:0]        mult,
  input  logic [HW-1:0]        shift,
  input  logic                 inBit,
  output logic signed [OW-1:0] outSample,
  output logic                 outValid
);
  localparam int PW = AW + MW + 1;

  logic signed [AW-1:0] integQ [NSTAGE];
  logic signed [AW-1:0] integD [NSTAGE];
  logic signed [AW-1:0] combQ  [NSTAGE];
  logic signed [AW-1:0] combD  [NSTAGE];
  logic signed [AW-1:0] integOut;
  logic signed [AW-1:0] combOut;
  logic signed [PW-1:0] product;
  logic signed [PW-1:0] shifted;
  logic signed [OW-1:0] satVal;
  logic [PW-OW:0]       topBits;

  always_comb begin
    logic signed [AW-1:0] chain;
    chain = inBit ? AW'(1) : '1;
    for (int k = 0; k < NSTAGE; k++) begin
      if (k < int'(nStages)) begin
        integD[k] = integQ[k] + chain;
        chain     = integD[k];
      end else begin
        integD[k] = '0;
      end
    end
    integOut = chain;
  end

  always_comb begin
    logic signed [AW-1:0] chain;
    chain = integOut;
    for (int k = 0; k < NSTAGE; k++) begin
      if (k < int'(nStages)) begin
        combD[k] = chain;
        chain    = chain - combQ[k];
      end else begin
        combD[k] = '0;
      end
    end
    combOut = chain;
  end

  always_comb begin
    product = PW'(combOut) * $signed({1'b0, mult});
    shifted = product >>> shift;
    topBits = shifted[PW-1:OW-1];
    if (topBits == '0 || topBits == '1) satVal = shifted[OW-1:0];
    else if (shifted[PW-1])             satVal = {1'b1, {(OW-1){1'b0}}};
    else                                satVal = {1'b0, {(OW-1){1'b1}}};
  end

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        integQ[k] <= '0;
        combQ[k]  <= '0;
      end else if (strobe.clear) begin
        integQ[k] <= '0;
        combQ[k]  <= '0;
      end else begin
        if (strobe.integ) integQ[k] <= integD[k];
        if (strobe.dump)  combQ[k]  <= combD[k];
      end
    end

    // R5: stages beyond the programmed count hold zero
    p_bypass_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.integ && strobe.dump && (SW'(k) >= nStages))
        |=> (integQ[k] == '0 && combQ[k] == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outSample <= '0;
    end else if (strobe.clear) begin
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      outValid <= strobe.dump;
      if (strobe.dump) outSample <= satVal;
    end
  end

  // R3: an output strobe only follows a completing input
  p_valid_after_dump_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.dump));

  // R7: clearing empties the first integrator and comb
  p_clear_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (integQ[0] == '0 && combQ[0] == '0));
endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] ctrlWord,
  input  logic        pdmBit,
  input  logic        pdmValid,
  output logic [23:0] pcmSample,
  output logic        pcmValid
);
  cic_cfg_t    cfg;
  cic_strobe_t strobe;
  logic signed [OUT_W-1:0] sampleS;

  always_comb begin
    cfg.stages = ctrlWord[3:0];
    cfg.ratio  = ctrlWord[8:4];
    cfg.mult   = ctrlWord[23:16];
    cfg.shift  = ctrlWord[29:24];
    cfg.enable = ctrlWord[31];
  end

  cic_ctrl #(.RATIO_BITS(RATIO_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (cfg.enable),
    .ratio   (cfg.ratio),
    .inValid (pdmValid),
    .strobe  (strobe)
  );

  cic_datapath #(
    .NSTAGE(MAX_STAGES), .SW(STAGE_W), .AW(ACC_W),
    .MW(MULT_W), .HW(SHIFT_W), .OW(OUT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .nStages   (cfg.stages),
    .mult      (cfg.mult),
    .shift     (cfg.shift),
    .inBit     (pdmBit),
    .outSample (sampleS),
    .outValid  (pcmValid)
  );

  assign pcmSample = sampleS;

  // R7: a disabled filter is silent from the next edge
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWord[31] |=> (!pcmValid && pcmSample == '0));
endmodule

// File: tb/sim_cic_decim.sv
module sim_cic_decim;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic        pdmBit = 1'b0;
  logic        pdmValid = 1'b0;
  logic [23:0] pcmSample;
  logic        pcmValid;

  int checks = 0;
  int errors = 0;
  string curReq = "R8";

  longint h [0:511];
  int     hLen;
  int     hist [$];
  int     acceptCnt;
  int     mN, mR, mMult, mShift;
  logic   expValid;
  longint expSample;
  logic [15:0] lfsr = 16'hACE1;

  cic_decim u0 (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord),
    .pdmBit(pdmBit), .pdmValid(pdmValid),
    .pcmSample(pcmSample), .pcmValid(pcmValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // R1: decode fields and build the N-fold boxcar response
  task automatic setCfg(input logic [31:0] w);
    longint tmp [0:511];
    ctrlWord = w;
    mN = int'(w[3:0]);
    mR = (w[8:4] == 0) ? 1 : int'(w[8:4]);
    mMult = int'(w[23:16]);
    mShift = int'(w[29:24]);
    hLen = 1;
    h[0] = 1;
    for (int s = 0; s < mN; s++) begin
      for (int i = 0; i < hLen + mR - 1; i++) begin
        tmp[i] = 0;
        for (int j = 0; j < mR; j++)
          if (i - j >= 0 && i - j < hLen) tmp[i] += h[i - j];
      end
      hLen = hLen + mR - 1;
      for (int i = 0; i < hLen; i++) h[i] = tmp[i];
    end
  endtask

  function automatic longint filterOut();
    longint acc = 0;
    longint prod, sh;
    int n = hist.size();
    for (int j = 0; j < hLen; j++)
      if (n - 1 - j >= 0) acc += h[j] * hist[n - 1 - j];
    prod = acc * mMult;
    sh = prod >>> mShift;
    if (sh > 64'sd8388607) sh = 8388607;
    if (sh < -64'sd8388608) sh = -8388608;
    return sh;
  endfunction

  task automatic compare();
    checks++;
    if (pcmValid !== expValid || $signed(pcmSample) !== 24'(expSample)) begin
      errors++;
      $display("FAIL %s valid=%0d sample=%0d expected valid=%0d sample=%0d",
               curReq, pcmValid, $signed(pcmSample), expValid, expSample);
    end
  endtask

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(input logic v, input logic b);
    pdmValid = v;
    pdmBit = b;
    @(posedge clk);
    if (!ctrlWord[31]) begin
      hist.delete();
      acceptCnt = 0;
      expValid = 1'b0;
      expSample = 0;
    end else if (v) begin
      hist.push_back(b ? 1 : -1);
      acceptCnt++;
      expValid = (acceptCnt % mR == 0);
      if (expValid) expSample = filterOut();
    end else begin
      expValid = 1'b0;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic restart(input logic [31:0] w, input string req);
    curReq = "R7";
    ctrlWord = {1'b0, ctrlWord[30:0]};
    step(1'b1, 1'b1);
    curReq = req;
    setCfg(w);
  endtask

  task automatic runPattern(input int n, input int kind);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (kind)
        0: step(1'b1, lfsr[0]);
        1: step(1'b1, 1'b1);
        2: step(1'b1, 1'b0);
        default: step(lfsr[3] | lfsr[7], lfsr[0]);
      endcase
    end
  endtask

  initial begin
    expValid = 1'b0;
    expSample = 0;
    acceptCnt = 0;
    setCfg(32'h0);
    repeat (3) @(negedge clk);
    curReq = "R8";
    compare();
    rstN = 1'b1;
    @(negedge clk);
    compare();

    // R4: default setting with a pseudo-random stream
    restart(cic_pkg::CTRL_DEFAULT, "R4");
    runPattern(300, 0);
    // R6: positive and negative saturation
    restart(32'h80FF_0087, "R6");
    runPattern(120, 1);
    restart(32'h80FF_0087, "R6");
    runPattern(120, 2);
    // R6: maximal shift keeps the sign
    restart(32'hBFFF_0033, "R6");
    runPattern(60, 0);
    // R5: zero stages pass the mapped bit
    restart(32'h8003_0050, "R5");
    runPattern(60, 0);
    // R5: fifteen stages at ratio two
    restart(32'h8A01_002F, "R5");
    runPattern(200, 0);
    // R3: ratio field zero acts as one
    restart(32'h8001_0002, "R3");
    runPattern(40, 0);
    // R2 / R3: ratio 31 with gapped strobes
    restart(32'h8001_01F3, "R2");
    runPattern(400, 3);
    // R7: disable mid-stream with strobes still arriving
    restart(32'h8005_0052, "R7");
    runPattern(13, 0);
    curReq = "R7";
    ctrlWord = {1'b0, ctrlWord[30:0]};
    runPattern(6, 1);
    ctrlWord = {1'b1, ctrlWord[30:0]};
    runPattern(60, 0);
    // R1: unused bits set, output must follow the model
    restart(32'hC080_FE85, "R1");
    runPattern(150, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule